// File: doc/BRIEF.md
# Unlock-Protected Flash Command Sequencer

This block sits in front of a byte-wide flash array. It watches the write cycles on the flash side of a shared memory bus and recognises the multi-cycle command sequences that guard every change to the array. Each sequence opens with two unlock writes to fixed addresses. When a complete program, sector-erase or bank-erase sequence arrives, the block raises a one-cycle start pulse. With the pulse it gives the kind of operation and the target address and data, which go to a separate operation unit. That unit does the timing of the operation and reports back through a busy flag. While the flag is high, every write cycle is discarded.

The block also owns an identification mode. In that mode, array reads are replaced with a manufacturer byte and a device byte. A short unlock sequence enters the mode and a matching one leaves it. A write strobe is one write cycle. The address is taken when the strobe rises and the data when it falls. Only the low command-address bits are compared against the unlock addresses.

Top module: `unlock_cmd_sequencer`

## Requirements
- R1: The writes 5555h/AAh, 2AAAh/55h, 5555h/A0h followed by any address/data raise op_start with op_kind=1 (program), op_addr equal to the full fourth address and op_data equal to the fourth data.
- R2: The writes 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h and then any address with data 30h raise op_start with op_kind=2 (sector erase) and op_data=30h. op_addr is the sixth address with bits 11..0 cleared, so bits 18..12 select a 4 KB sector.
- R3: The same five opening writes followed by 5555h/10h raise op_start with op_kind=3 (bank erase), op_addr=0 and op_data=10h.
- R4: 5555h/AAh, 2AAAh/55h, 5555h/90h sets id_mode to 1. 5555h/AAh, 2AAAh/55h, 5555h/F0h clears id_mode to 0.
- R5: While id_mode=1, rd_data is BFh when addr bit 0 is 0 and the low byte of DEVICE_ID when addr bit 0 is 1. The other address bits are ignored. While id_mode=0, rd_data equals array_rdata.
- R6: Command cycles compare only address bits 14..0. Bits 18..15 have no effect on recognition.
- R7: A write that does not match the expected next step returns the sequencer to its idle state. A later sequence must start again with 5555h/AAh.
- R8: While op_busy=1, every completed write cycle is ignored, including ID entry and exit. The sequence position and id_mode are kept, and no op_start is raised.
- R9: A write cycle's address is the addr value sampled on the clock where wr_strobe is first seen high. Its data is the wdata value sampled on the clock where wr_strobe is first seen low again.
- R10: op_start lasts exactly one cycle and comes two clocks after the strobe is seen low. op_kind is nonzero only while op_start is high, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_strobe | input | 1 | Synchronised flash write strobe, high during a write |
| addr | input | 19 | Shared address bus |
| wdata | input | 8 | Write data bus |
| op_busy | input | 1 | Operation unit is programming or erasing |
| array_rdata | input | 8 | Read data from the flash array |
| op_start | output | 1 | One-cycle start pulse for the operation unit |
| op_kind | output | 2 | 0 none, 1 program, 2 sector erase, 3 bank erase |
| op_addr | output | 19 | Target address of the started operation |
| op_data | output | 8 | Data of the started operation |
| id_mode | output | 1 | Identification read mode active |
| rd_data | output | 8 | Read data after the identification substitution |

## Verification
The bench goes after aborts that happen deep inside a sequence. If such an abort left the state machine partway, a later stray 5555h/A0h followed by a data write would start an unintended program. It sends busy writes in the middle of a sequence. A design that reset its position on a busy cycle would drop the next valid step, and one that acted on the cycle would start early. It moves the address and data buses while the strobe is high, so a design that sampled both at the same strobe edge would report the wrong target. It also sets the upper address bits on command cycles, which a full-width compare would reject.

// File: rtl/unlock_seq_pkg.sv
// Package: shared types and constants for the unlock command sequencer.
// Assumes byte-wide command data; the command address constants are 16 bits
// wide and are sliced to the compared width by the users.
package unlock_seq_pkg;

    typedef enum logic [1:0] {
        OPK_NONE = 2'd0,
        OPK_PROG = 2'd1,
        OPK_SECT = 2'd2,
        OPK_BANK = 2'd3
    } op_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNL1,
        ST_UNL2,
        ST_PROG_TGT,
        ST_ERA_SETUP,
        ST_ERA_UNL1,
        ST_ERA_UNL2
    } seq_state_e;

    // Match flags for one completed write cycle.
    typedef struct packed {
        logic key1;      // first unlock write
        logic key2;      // second unlock write
        logic at_main;   // address is the main command address
        logic d_prog;
        logic d_erase;
        logic d_id_in;
        logic d_id_out;
        logic d_bank;
        logic d_sect;
    } cmd_hits_t;

    localparam logic [15:0] MAIN_ADDR  = 16'h5555;
    localparam logic [15:0] ALT_ADDR   = 16'h2AAA;
    localparam logic [7:0]  KEY1_DATA  = 8'hAA;
    localparam logic [7:0]  KEY2_DATA  = 8'h55;
    localparam logic [7:0]  CODE_PROG  = 8'hA0;
    localparam logic [7:0]  CODE_ERASE = 8'h80;
    localparam logic [7:0]  CODE_IDIN  = 8'h90;
    localparam logic [7:0]  CODE_IDOUT = 8'hF0;
    localparam logic [7:0]  CODE_BANK  = 8'h10;
    localparam logic [7:0]  CODE_SECT  = 8'h30;
    localparam logic [7:0]  MFR_BYTE   = 8'hBF;

endpackage

// File: rtl/strobe_capture.sv
// Module: strobe_capture
// Turns the synchronised write strobe into one completed write cycle.
// The address is held from the clock where the strobe is first seen high.
// The data is held from the clock where the strobe is first seen low again.
// cyc_v pulses for one cycle after that falling clock.
// Assumes wr_strobe is already synchronous to clk.
module strobe_capture #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              cyc_v,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [DATA_W-1:0] cyc_data
);
    logic strobe_q;
    logic rise_w;
    logic fall_w;

    assign rise_w = wr_strobe & ~strobe_q;
    assign fall_w = ~wr_strobe & strobe_q;

    // Purpose: remember the strobe level and capture address and data at its edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            cyc_v    <= 1'b0;
            cyc_addr <= '0;
            cyc_data <= '0;
        end else begin
            strobe_q <= wr_strobe;
            cyc_v    <= fall_w;
            if (rise_w) cyc_addr <= addr;
            if (fall_w) cyc_data <= wdata;
        end
    end
endmodule

// File: rtl/cmd_match.sv
// Module: cmd_match
// Combinational decoder that compares one captured write cycle against the
// unlock addresses and the command codes.
// Only the low CMD_ADDR_W address bits take part in the compare.
module cmd_match
    import unlock_seq_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 8,
    parameter int CMD_ADDR_W = 15
) (
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [DATA_W-1:0] cyc_data,
    output cmd_hits_t         hits
);
    localparam logic [CMD_ADDR_W-1:0] MAIN_A = MAIN_ADDR[CMD_ADDR_W-1:0];
    localparam logic [CMD_ADDR_W-1:0] ALT_A  = ALT_ADDR[CMD_ADDR_W-1:0];

    logic [CMD_ADDR_W-1:0] low_a;
    logic                  at_alt;
    logic                  at_main;

    assign low_a   = cyc_addr[CMD_ADDR_W-1:0];
    assign at_main = (low_a == MAIN_A);
    assign at_alt  = (low_a == ALT_A);

    // Purpose: form the per-cycle match flags.
    always_comb begin
        hits          = '0;
        hits.at_main  = at_main;
        hits.key1     = at_main && (cyc_data[7:0] == KEY1_DATA);
        hits.key2     = at_alt  && (cyc_data[7:0] == KEY2_DATA);
        hits.d_prog   = (cyc_data[7:0] == CODE_PROG);
        hits.d_erase  = (cyc_data[7:0] == CODE_ERASE);
        hits.d_id_in  = (cyc_data[7:0] == CODE_IDIN);
        hits.d_id_out = (cyc_data[7:0] == CODE_IDOUT);
        hits.d_bank   = (cyc_data[7:0] == CODE_BANK);
        hits.d_sect   = (cyc_data[7:0] == CODE_SECT);
    end
endmodule

// File: rtl/seq_fsm.sv
// Module: seq_fsm
// Sequence state machine. It advances once on every completed write cycle
// that arrives while the operation unit is idle. A mismatch returns it to
// idle. It issues the start pulse and owns the identification mode flag.
// Assumes cyc_v is a single-cycle pulse.
module seq_fsm
    import unlock_seq_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 8,
    parameter int SECT_LSB = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_v,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [DATA_W-1:0] cyc_data,
    input  cmd_hits_t         hits,
    input  logic              op_busy,
    output logic              op_start,
    output op_kind_e          op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              id_mode
);
    seq_state_e        state_q;
    seq_state_e        state_d;
    logic              fire;
    op_kind_e          fire_kind;
    logic [ADDR_W-1:0] fire_addr;
    logic              id_set;
    logic              id_clr;

    // Purpose: decide the next position and any action for the current cycle.
    always_comb begin
        state_d   = ST_IDLE;
        fire      = 1'b0;
        fire_kind = OPK_NONE;
        fire_addr = cyc_addr;
        id_set    = 1'b0;
        id_clr    = 1'b0;
        unique case (state_q)
            ST_IDLE:  if (hits.key1) state_d = ST_UNL1;
            ST_UNL1:  if (hits.key2) state_d = ST_UNL2;
            ST_UNL2: begin
                if (hits.at_main && hits.d_prog)  state_d = ST_PROG_TGT;
                if (hits.at_main && hits.d_erase) state_d = ST_ERA_SETUP;
                if (hits.at_main && hits.d_id_in)  id_set = 1'b1;
                if (hits.at_main && hits.d_id_out) id_clr = 1'b1;
            end
            ST_PROG_TGT: begin
                fire      = 1'b1;
                fire_kind = OPK_PROG;
            end
            ST_ERA_SETUP: if (hits.key1) state_d = ST_ERA_UNL1;
            ST_ERA_UNL1:  if (hits.key2) state_d = ST_ERA_UNL2;
            ST_ERA_UNL2: begin
                if (hits.d_sect) begin
                    fire      = 1'b1;
                    fire_kind = OPK_SECT;
                    fire_addr = {cyc_addr[ADDR_W-1:SECT_LSB], {SECT_LSB{1'b0}}};
                end else if (hits.at_main && hits.d_bank) begin
                    fire      = 1'b1;
                    fire_kind = OPK_BANK;
                    fire_addr = '0;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Purpose: advance the sequence on accepted cycles and register the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            id_mode  <= 1'b0;
            op_start <= 1'b0;
            op_kind  <= OPK_NONE;
            op_addr  <= '0;
            op_data  <= '0;
        end else begin
            op_start <= 1'b0;
            op_kind  <= OPK_NONE;
            if (cyc_v && !op_busy) begin
                state_q <= state_d;
                if (id_set) id_mode <= 1'b1;
                if (id_clr) id_mode <= 1'b0;
                if (fire) begin
                    op_start <= 1'b1;
                    op_kind  <= fire_kind;
                    op_addr  <= fire_addr;
                    op_data  <= cyc_data;
                end
            end
        end
    end
endmodule

// File: rtl/unlock_cmd_sequencer.sv
// Module: unlock_cmd_sequencer (top)
// Recognises unlock-protected flash command sequences and raises a start
// pulse for the operation unit. In identification mode, array reads are
// replaced with the identification bytes.
// Assumes wr_strobe is synchronised and op_busy comes from the operation unit.
module unlock_cmd_sequencer
    import unlock_seq_pkg::*;
#(
    parameter int          ADDR_W     = 19,
    parameter int          DATA_W     = 8,
    parameter int          CMD_ADDR_W = 15,
    parameter int          SECT_LSB   = 12,
    parameter logic [15:0] DEVICE_ID  = 16'h00A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              op_busy,
    input  logic [DATA_W-1:0] array_rdata,
    output logic              op_start,
    output logic [1:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              id_mode,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [DATA_W-1:0] ID_DEV = DATA_W'(DEVICE_ID[7:0]);
    localparam logic [DATA_W-1:0] ID_MFR = DATA_W'(MFR_BYTE);

    logic              cyc_v;
    logic [ADDR_W-1:0] cyc_addr;
    logic [DATA_W-1:0] cyc_data;
    cmd_hits_t         hits;
    op_kind_e          kind_w;

    strobe_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) cap_i (
        .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .addr(addr),
        .wdata(wdata), .cyc_v(cyc_v), .cyc_addr(cyc_addr), .cyc_data(cyc_data)
    );

    cmd_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_ADDR_W(CMD_ADDR_W)) match_i (
        .cyc_addr(cyc_addr), .cyc_data(cyc_data), .hits(hits)
    );

    seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(SECT_LSB)) fsm_i (
        .clk(clk), .rst_n(rst_n), .cyc_v(cyc_v), .cyc_addr(cyc_addr),
        .cyc_data(cyc_data), .hits(hits), .op_busy(op_busy),
        .op_start(op_start), .op_kind(kind_w), .op_addr(op_addr),
        .op_data(op_data), .id_mode(id_mode)
    );

    assign op_kind = kind_w;

    // Purpose: substitute the identification bytes for array reads in ID mode.
    always_comb begin
        if (id_mode) rd_data = addr[0] ? ID_DEV : ID_MFR;
        else         rd_data = array_rdata;
    end
endmodule

// File: rtl/unlock_cmd_sequencer_checker.sv
// Module: unlock_cmd_sequencer_checker
// Assertion checker, attached to the top module by bind below.
module unlock_cmd_sequencer_checker #(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 8,
    parameter int SECT_LSB = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_v,
    input logic              op_busy,
    input logic              op_start,
    input logic [1:0]        op_kind,
    input logic [ADDR_W-1:0] op_addr,
    input logic              id_mode,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rd_data
);
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !op_start);

    a_r10_kind_only_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start == (op_kind != 2'd0)));

    a_r1_start_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> $past(cyc_v) && !$past(op_busy));

    a_r2_sector_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_kind == 2'd2) |-> (op_addr[SECT_LSB-1:0] == '0));

    a_r3_bank_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_kind == 2'd3) |-> (op_addr == '0));

    a_r8_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_v && op_busy) |=> (!op_start && $stable(id_mode)));

    a_r4_id_change_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(id_mode) |-> ($past(cyc_v) && !$past(op_busy)));

    a_r5_mfr_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (id_mode && !addr[0]) |-> (rd_data == DATA_W'(8'hBF)));
endmodule

bind unlock_cmd_sequencer unlock_cmd_sequencer_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(SECT_LSB)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cyc_v(cyc_v), .op_busy(op_busy),
    .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr),
    .id_mode(id_mode), .addr(addr), .rd_data(rd_data)
);

// File: tb/unlock_cmd_sequencer_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the stimulus tasks push the expected start events, and a
// monitor pops and compares them whenever op_start is seen.
module unlock_cmd_sequencer_tb_top;
    typedef struct {
        logic [1:0]  kind;
        logic [18:0] addr;
        logic [7:0]  data;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_strobe = 1'b0;
    logic [18:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        op_busy = 1'b0;
    logic [7:0]  array_rdata = 8'h3C;
    logic        op_start;
    logic [1:0]  op_kind;
    logic [18:0] op_addr;
    logic [7:0]  op_data;
    logic        id_mode;
    logic [7:0]  rd_data;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    unlock_cmd_sequencer #(.DEVICE_ID(16'h00A5)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .addr(addr),
        .wdata(wdata), .op_busy(op_busy), .array_rdata(array_rdata),
        .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr),
        .op_data(op_data), .id_mode(id_mode), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_op(input logic [1:0] k, input logic [18:0] a,
                             input logic [7:0] d, input string req);
        exp_t e;
        e.kind = k; e.addr = a; e.data = d; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic wr(input logic [18:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_strobe = 1'b1;
        @(negedge clk);
        @(negedge clk); wr_strobe = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Address moves after the rising sample, data is valid only at the fall.
    task automatic wr_split(input logic [18:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = 8'hEE; wr_strobe = 1'b1;
        @(negedge clk); addr = 19'h0; wdata = d;
        @(negedge clk); wr_strobe = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic unlock2();
        wr(19'h05555, 8'hAA);
        wr(19'h02AAA, 8'h55);
    endtask

    // Monitor: compare each start pulse against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && op_start) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R7/R8 unexpected op_start", {30'd0, op_kind}, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(op_kind == e.kind, {e.req, " kind"}, {30'd0, op_kind}, {30'd0, e.kind});
                chk(op_addr == e.addr, {e.req, " addr"}, {13'd0, op_addr}, {13'd0, e.addr});
                chk(op_data == e.data, {e.req, " data"}, {24'd0, op_data}, {24'd0, e.data});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R10, R5)
        chk(op_start == 1'b0, "R10 reset op_start", {31'd0, op_start}, 0);
        chk(op_kind == 2'd0, "R10 reset op_kind", {30'd0, op_kind}, 0);
        chk(id_mode == 1'b0, "R4 reset id_mode", {31'd0, id_mode}, 0);
        chk(rd_data == 8'h3C, "R5 normal read passthrough", {24'd0, rd_data}, 32'h3C);

        // R1 program
        expect_op(2'd1, 19'h12345, 8'h5A, "R1 program");
        unlock2(); wr(19'h05555, 8'hA0); wr(19'h12345, 8'h5A);

        // R9 address at strobe rise, data at strobe fall
        expect_op(2'd1, 19'h3BEEF, 8'h77, "R9 split capture");
        unlock2(); wr(19'h05555, 8'hA0); wr_split(19'h3BEEF, 8'h77);

        // R2 sector erase
        expect_op(2'd2, 19'h43000, 8'h30, "R2 sector erase");
        unlock2(); wr(19'h05555, 8'h80); unlock2(); wr(19'h43ABC, 8'h30);

        // R3 bank erase
        expect_op(2'd3, 19'h00000, 8'h10, "R3 bank erase");
        unlock2(); wr(19'h05555, 8'h80); unlock2(); wr(19'h05555, 8'h10);

        // R6 upper address bits set on the command cycles
        expect_op(2'd1, 19'h7FFFF, 8'h00, "R6 upper bits ignored");
        wr(19'h7D555, 8'hAA); wr(19'h7AAAA, 8'h55); wr(19'h4D555, 8'hA0);
        wr(19'h7FFFF, 8'h00);

        // R7 abort at the command step, then the rest of the sequence alone
        unlock2(); wr(19'h05555, 8'h77);
        wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0); wr(19'h01234, 8'h5A);
        // R7 abort in the erase stage, then a lone sector-erase cycle
        unlock2(); wr(19'h05555, 8'h80); unlock2(); wr(19'h05555, 8'h20);
        wr(19'h12000, 8'h30);
        // R7 a full sequence still works afterwards
        expect_op(2'd1, 19'h00001, 8'hC3, "R7 after abort");
        unlock2(); wr(19'h05555, 8'hA0); wr(19'h00001, 8'hC3);

        // R4 / R5 identification mode
        unlock2(); wr(19'h05555, 8'h90);
        chk(id_mode == 1'b1, "R4 id entry", {31'd0, id_mode}, 1);
        @(negedge clk); addr = 19'h00000; #1;
        chk(rd_data == 8'hBF, "R5 mfr byte", {24'd0, rd_data}, 32'hBF);
        @(negedge clk); addr = 19'h00001; #1;
        chk(rd_data == 8'hA5, "R5 device byte", {24'd0, rd_data}, 32'hA5);
        @(negedge clk); addr = 19'h40002; #1;
        chk(rd_data == 8'hBF, "R5 only bit 0 decoded", {24'd0, rd_data}, 32'hBF);
        unlock2(); wr(19'h05555, 8'hF0);
        chk(id_mode == 1'b0, "R4 id exit", {31'd0, id_mode}, 0);
        @(negedge clk); addr = 19'h00001; #1;
        chk(rd_data == 8'h3C, "R5 array after exit", {24'd0, rd_data}, 32'h3C);

        // R8 busy: full program and ID entry ignored
        op_busy = 1'b1;
        unlock2(); wr(19'h05555, 8'hA0); wr(19'h05000, 8'h11);
        unlock2(); wr(19'h05555, 8'h90);
        chk(id_mode == 1'b0, "R8 id entry ignored while busy", {31'd0, id_mode}, 0);
        op_busy = 1'b0;
        // R8 busy in the middle keeps the sequence position
        expect_op(2'd1, 19'h0ABCD, 8'h99, "R8 position kept across busy");
        unlock2();
        op_busy = 1'b1; wr(19'h05555, 8'hA0); op_busy = 1'b0;
        wr(19'h05555, 8'hA0); wr(19'h0ABCD, 8'h99);

        repeat (10) @(negedge clk);
        chk(sb_q.size() == 0, "R1/R2/R3 all expected starts seen", sb_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule